// File: doc/BRIEF.md
# Stereo Near-Clip Overflow Flag Generator

This block sits behind a two-channel audio decimator and watches the 20-bit two's complement sample that each channel produces. When a sample moves outside a near-clipping window, the block raises an active-high flag for that channel. The window is asymmetric: the upper limit is 0x70000 and the lower limit is 0x82FFF. The flag is set on the clock edge that takes in the offending sample, so no extra latency is added.

Once set, a flag stays high for a fixed number of sample periods, 4096 by default, and then drops by itself. A further out-of-window sample while the flag is high starts the hold period again. The two channels never affect each other. Samples are only evaluated in a clock cycle where the sample strobe is high. The synchronous active-low reset clears both flags and their hold state. A power-down is expected to drive the same reset.

Top module: `ovf_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flags and both hold counts are cleared, so both flags read 0 on the following cycle, including in the middle of a hold period.
- R2: On a clock edge where `smp_stb` is high and a channel's code, read as signed 20-bit, is greater than 0x70000 (for example 0x70001 or 0x7FFFF), that channel's flag is 1 in the very next cycle.
- R3: On a clock edge where `smp_stb` is high and a channel's code, read as signed 20-bit, is less than 0x82FFF (for example 0x82FFE or 0x80000), that channel's flag is 1 in the very next cycle.
- R4: The codes 0x70000 and 0x82FFF themselves, and every code that lies between them in signed order (such as 0x00000, 0xFFFFF and 0x90000), do not set a flag.
- R5: The left flag depends only on `code_l` and the right flag only on `code_r`. An overflow on one channel leaves the other channel's flag unchanged.
- R6: After the strobe that sets a flag, the flag stays 1 through the next 4095 strobes that carry in-window codes, and reads 0 after the 4096th such strobe.
- R7: An out-of-window code on a strobe while the flag is already high restarts the hold period. The flag then clears 4096 in-window strobes after that strobe.
- R8: A code presented while `smp_stb` is low has no effect. An out-of-window code without a strobe does not set the flag.
- R9: A flag changes value only in the cycle after a strobe. Between strobes it holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also used for power-down |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| code_l | input | 20 | Left channel sample, two's complement |
| code_r | input | 20 | Right channel sample, two's complement |
| ovf_l | output | 1 | Left channel overflow flag, active high |
| ovf_r | output | 1 | Right channel overflow flag, active high |

## Verification
Several properties are checked on every cycle. A strobed out-of-window code must raise its flag one cycle later. A flag may only rise after a strobed hit on its own channel. A flag must stay steady between strobes, and the hold count must never go past its limit. Other behaviours can only be shown by the bench's scenarios: the exact 4096-strobe hold length, the restart on a new hit, the exact boundary codes that must not trigger, and the clearing of a hold in progress by reset.

// File: rtl/ovf_pkg.sv
// Package: shared widths, limits and channel indices for the overflow flag block.
// Assumes samples are two's complement and that the upper limit is above the lower one.
package ovf_pkg;
    localparam int unsigned CODE_W_DEF = 20;
    localparam int unsigned HOLD_DEF   = 4096;
    localparam logic [19:0] HI_DEF     = 20'h70000;
    localparam logic [19:0] LO_DEF     = 20'h82FFF;
    localparam int unsigned N_CH       = 2;

    typedef enum int unsigned {
        CH_LEFT  = 0,
        CH_RIGHT = 1
    } chan_e;
endpackage

// File: rtl/ovf_cmp.sv
// Module: window compare for one channel.
// Reports a hit when the signed code lies strictly above HI or strictly below LO.
// Assumes the limits are given in the same width and coding as the code.
module ovf_cmp #(
    parameter int unsigned           CODE_W = 20,
    parameter logic [CODE_W-1:0]     HI     = 20'h70000,
    parameter logic [CODE_W-1:0]     LO     = 20'h82FFF
) (
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic above;
    logic below;

    // Signed compare against each limit and merge the two results
    always_comb begin
        above = $signed(code) > $signed(HI);
        below = $signed(code) < $signed(LO);
        hit   = above | below;
    end
endmodule

// File: rtl/ovf_hold.sv
// Module: hold counter for one channel flag.
// Loads HOLD on a strobed hit and counts down on each strobe without a hit.
// The flag is high while the count is non-zero.
// Assumes hits are only meaningful when the strobe is high.
module ovf_hold #(
    parameter int unsigned HOLD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic hit,
    output logic flag
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count register: restart on a hit, otherwise count down once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stb) begin
            if (hit) begin
                cnt_q <= CNT_W'(HOLD);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Flag decode from the count
    always_comb flag = (cnt_q != '0);

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && hit) |=> flag);                                   // R2
    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(stb && hit));                       // R5
    AST_STEADY_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(flag));                                  // R9
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(HOLD));                                   // R6
endmodule

// File: rtl/ovf_detect.sv
// Module: two-channel near-clip overflow flag generator (top).
// Each channel has its own window compare and hold counter, built by a generate loop.
// Assumes a one-cycle sample strobe and a synchronous active-low reset.
module ovf_detect
    import ovf_pkg::*;
#(
    parameter int unsigned       CODE_W = CODE_W_DEF,
    parameter int unsigned       HOLD   = HOLD_DEF,
    parameter logic [CODE_W-1:0] HI     = HI_DEF,
    parameter logic [CODE_W-1:0] LO     = LO_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [CODE_W-1:0] code_l,
    input  logic [CODE_W-1:0] code_r,
    output logic              ovf_l,
    output logic              ovf_r
);
    logic [CODE_W-1:0] code_a [N_CH];
    logic [N_CH-1:0]   hit_a;
    logic [N_CH-1:0]   flag_a;

    // Gather the channel codes into an indexed array
    always_comb begin
        code_a[CH_LEFT]  = code_l;
        code_a[CH_RIGHT] = code_r;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        ovf_cmp #(.CODE_W(CODE_W), .HI(HI), .LO(LO)) u_cmp (
            .code (code_a[ch]),
            .hit  (hit_a[ch])
        );
        ovf_hold #(.HOLD(HOLD)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb),
            .hit   (hit_a[ch]),
            .flag  (flag_a[ch])
        );
    end

    // Drive the output flags from the channel array
    always_comb begin
        ovf_l = flag_a[CH_LEFT];
        ovf_r = flag_a[CH_RIGHT];
    end

    AST_LEFT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && ($signed(code_l) > $signed(HI))) |=> ovf_l);   // R2
    AST_RIGHT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && ($signed(code_r) < $signed(LO))) |=> ovf_r);   // R3
    AST_LEFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && !ovf_l) |=> !ovf_l);                          // R8
endmodule

// File: tb/sim_ovf_detect.sv
module sim_ovf_detect;
    localparam int CLK_PER = 10;
    localparam int HOLD    = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [19:0] code_l = '0;
    logic [19:0] code_r = '0;
    logic        ovf_l;
    logic        ovf_r;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    ovf_detect u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .code_l(code_l), .code_r(code_r), .ovf_l(ovf_l), .ovf_r(ovf_r)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One strobe cycle followed by one idle cycle; outputs settled at return
    task automatic strobe(input logic [19:0] l, input logic [19:0] r);
        @(negedge clk);
        smp_stb = 1'b1; code_l = l; code_r = r;
        @(negedge clk);
        smp_stb = 1'b0; code_l = '0; code_r = '0;
    endtask

    task automatic idle_strobes(input int n);
        for (int i = 0; i < n; i++) strobe(20'h00000, 20'h00000);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset left", ovf_l, 1'b0);
        chk("R1 reset right", ovf_r, 1'b0);
    endtask

    task automatic t_window();
        strobe(20'h70000, 20'h82FFF);
        chk("R4 upper limit", ovf_l, 1'b0);
        chk("R4 lower limit", ovf_r, 1'b0);
        strobe(20'hFFFFF, 20'h90000);
        chk("R4 inside l", ovf_l, 1'b0);
        chk("R4 inside r", ovf_r, 1'b0);
        strobe(20'h70001, 20'h00000);
        chk("R2 above left", ovf_l, 1'b1);
        chk("R5 right untouched", ovf_r, 1'b0);
        do_reset();
        strobe(20'h00000, 20'h82FFE);
        chk("R3 below right", ovf_r, 1'b1);
        chk("R5 left untouched", ovf_l, 1'b0);
        do_reset();
        strobe(20'h80000, 20'h7FFFF);
        chk("R3 most negative", ovf_l, 1'b1);
        chk("R2 most positive", ovf_r, 1'b1);
        do_reset();
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        code_l = 20'h7FFFF; code_r = 20'h80000;
        repeat (5) @(negedge clk);
        chk("R8 left no strobe", ovf_l, 1'b0);
        chk("R8 right no strobe", ovf_r, 1'b0);
        code_l = '0; code_r = '0;
    endtask

    task automatic t_hold();
        strobe(20'h7FFFF, 20'h00000);
        idle_strobes(HOLD - 1);
        chk("R6 held at 4095", ovf_l, 1'b1);
        repeat (20) @(negedge clk);
        chk("R9 steady between strobes", ovf_l, 1'b1);
        idle_strobes(1);
        chk("R6 cleared at 4096", ovf_l, 1'b0);
    endtask

    task automatic t_retrigger();
        strobe(20'h00000, 20'h80000);
        idle_strobes(2000);
        strobe(20'h00000, 20'h82000);
        idle_strobes(HOLD - 1);
        chk("R7 still held", ovf_r, 1'b1);
        idle_strobes(1);
        chk("R7 cleared after restart", ovf_r, 1'b0);
    endtask

    task automatic t_reset_mid();
        strobe(20'h7FFFF, 20'h80000);
        idle_strobes(10);
        do_reset();
        chk("R1 mid-hold left", ovf_l, 1'b0);
        chk("R1 mid-hold right", ovf_r, 1'b0);
        idle_strobes(3);
        chk("R1 stays clear", ovf_l, 1'b0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_no_strobe();
        t_hold();
        t_retrigger();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule